// File: doc/BRIEF.md
# Byte-Wide SPI Master Controller

This block is a memory-mapped SPI master that moves one byte per software write. A 16-bit control word at offset 0 holds the serial clock rate, the target device, a chip-select hold flag, an interrupt enable and a bus enable. An 8-bit data register sits at offset 2. Writing the data register while the bus is enabled and idle shifts that byte out MSB first in SPI mode 0 and captures the byte returned by the device. The captured byte can be read back from the same offset once the transfer has finished.

The serial clock comes from the block clock, which is taken as a 16 MHz reference. It is divided by 4, 8, 16 or 32 and rests low between transfers. Each device has its own active-low chip select. The hold flag keeps the selected line asserted after a byte, so software can chain bytes into a multi-byte command. A one-cycle interrupt pulse can mark the end of each byte.

The sequencer has four states. IDLE waits for an accepted data write (IDLE to SCK_LO). SCK_LO drives the serial clock low for one half period and samples the input line as it leaves (SCK_LO to SCK_HI). SCK_HI drives the clock high for one half period and then moves to the next bit (SCK_HI to SCK_LO). After the last bit it goes to TAIL (SCK_HI to TAIL). TAIL keeps the clock low for a closing half period, publishes the received byte and returns to IDLE (TAIL to IDLE).

Top module: `bspi_master`

## Requirements
- R1: After reset both registers read as zero, every chip select is high, the serial clock is low, and busy and irq are low.
- R2: The control word places the rate in bits 1:0, busy in bit 7, the device code in bits 9:8, the size flag in bit 10, hold in bit 11, the interrupt enable in bit 14 and the bus enable in bit 15. Bits 2 to 6 and 12 to 13 always read zero, and writing bit 7 has no effect.
- R3: Rate codes 0, 1, 2 and 3 give serial clock periods of 4, 8, 16 and 32 block clock cycles. Each period has equal low and high halves, and the clock is low whenever the block is idle.
- R4: A data write accepted in idle raises busy for exactly 17 half periods. In that time eight clock pulses occur, each preceded by a low half. The output line carries the byte MSB first, changes only on a falling clock edge or at the start, and the input line is sampled on each rising edge.
- R5: Reading offset 2 after busy falls returns the eight bits sampled during that transfer, first sample in bit 7, in the low byte, with zeros above.
- R6: Device code n (0 to 2) drives chip select n low for the whole transfer while the bus is enabled. Code 3 selects no line. At most one line is ever low.
- R7: If hold is 1 when a transfer ends, the selected line stays low afterwards. If hold is 0, the line is released. Clearing hold while idle does not release the line until the next transfer ends.
- R8: With bus enable at 0, all chip selects are high, even a held one, and data writes start nothing.
- R9: Writes to either register while busy are ignored.
- R10: irq pulses for one cycle, in the cycle busy falls, only if the interrupt enable is 1.
- R11: The size flag is stored and read back, but every transfer is 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz reference and block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 is control, 2 is data |
| reg_wdata | input | 16 | Write data (the data register uses bits 7:0) |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_DEV | Active-low chip selects, one per device |
| busy | output | 1 | High while a transfer runs |
| irq | output | 1 | One-cycle end-of-transfer interrupt |

## Verification
The assertions assume spi_miso is held steady around each rising serial clock edge. The bench model drives it on the falling block clock edge, from the bit index of the transfer in progress. They also assume register writes arrive as single-cycle strobes synchronous to clk. The bench raises each strobe just after a falling edge and drops it one cycle later. Writes issued during a transfer are sent on purpose, because the ignore rules cover them.

// File: rtl/bspi_pkg.sv
package bspi_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCK_LO,
        ST_SCK_HI,
        ST_TAIL
    } bspi_state_e;

    typedef struct packed {
        logic       bus_en;
        logic       irq_en;
        logic       hold;
        logic       size16;
        logic [1:0] dev;
        logic [1:0] rate;
    } bspi_ctrl_t;

    localparam int CTRL_RATE_LSB = 0;
    localparam int CTRL_BUSY     = 7;
    localparam int CTRL_DEV_LSB  = 8;
    localparam int CTRL_SIZE     = 10;
    localparam int CTRL_HOLD     = 11;
    localparam int CTRL_IRQ      = 14;
    localparam int CTRL_EN       = 15;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd2;

endpackage

// File: rtl/bspi_regs.sv
module bspi_regs
    import bspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [15:0]       wdata,
    input  logic              busy,
    input  logic [BYTE_W-1:0] rx_byte,
    output bspi_ctrl_t        ctrl,
    output logic [15:0]       rdata,
    output logic              go,
    output logic [BYTE_W-1:0] tx_byte
);

    logic ctrl_wr;

    assign ctrl_wr = wr && (addr == ADDR_CTRL) && !busy;
    assign go      = wr && (addr == ADDR_DATA) && !busy && ctrl.bus_en;
    assign tx_byte = wdata[BYTE_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl.bus_en <= wdata[CTRL_EN];
            ctrl.irq_en <= wdata[CTRL_IRQ];
            ctrl.hold   <= wdata[CTRL_HOLD];
            ctrl.size16 <= wdata[CTRL_SIZE];
            ctrl.dev    <= wdata[CTRL_DEV_LSB +: 2];
            ctrl.rate   <= wdata[CTRL_RATE_LSB +: 2];
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_CTRL: begin
                rdata[CTRL_EN]             = ctrl.bus_en;
                rdata[CTRL_IRQ]            = ctrl.irq_en;
                rdata[CTRL_HOLD]           = ctrl.hold;
                rdata[CTRL_SIZE]           = ctrl.size16;
                rdata[CTRL_DEV_LSB +: 2]   = ctrl.dev;
                rdata[CTRL_BUSY]           = busy;
                rdata[CTRL_RATE_LSB +: 2]  = ctrl.rate;
            end
            ADDR_DATA: rdata[BYTE_W-1:0] = rx_byte;
            default:   rdata = '0;
        endcase
    end

    AST_CTRL_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ctrl)); // R9

endmodule

// File: rtl/bspi_clkdiv.sv
module bspi_clkdiv #(
    parameter int DIV_BASE = 4,
    parameter int RATE_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);

    localparam int MAX_HALF = (DIV_BASE << ((1 << RATE_W) - 1)) / 2;
    localparam int CNT_W    = $clog2(MAX_HALF + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   half_len;

    always_comb begin
        half_len = (CNT_W+1)'(DIV_BASE / 2) << rate;
    end

    assign tick = run && ({1'b0, cnt} == (half_len - 1'b1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/bspi_shifter.sv
module bspi_shifter
    import bspi_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);

    localparam int BIT_W = $clog2(DATA_W);

    bspi_state_e       state_q, state_d;
    logic [DATA_W-1:0] tx_sh, rx_sh;
    logic [BIT_W-1:0]  bit_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go)   state_d = ST_SCK_LO;
            ST_SCK_LO: if (tick) state_d = ST_SCK_HI;
            ST_SCK_HI: if (tick) state_d = (bit_cnt == '0) ? ST_TAIL : ST_SCK_LO;
            ST_TAIL:   if (tick) state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q != ST_IDLE);
        sclk = (state_q == ST_SCK_HI);
        mosi = tx_sh[DATA_W-1];
        done = (state_q == ST_TAIL) && tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_byte <= '0;
            bit_cnt <= '0;
        end else begin
            if (state_q == ST_IDLE && go) begin
                tx_sh   <= tx_byte;
                bit_cnt <= BIT_W'(DATA_W - 1);
            end
            if (state_q == ST_SCK_LO && tick) begin
                rx_sh <= {rx_sh[DATA_W-2:0], miso};
            end
            if (state_q == ST_SCK_HI && tick && bit_cnt != '0) begin
                tx_sh   <= tx_sh << 1;
                bit_cnt <= bit_cnt - 1'b1;
            end
            if (done) begin
                rx_byte <= rx_sh;
            end
        end
    end

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk); // R3

    AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$fell(sclk)) |-> $stable(mosi)); // R4

endmodule

// File: rtl/bspi_csel.sv
module bspi_csel #(
    parameter int NUM_DEV = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic [1:0]         dev,
    input  logic               hold,
    input  logic               busy,
    input  logic               done,
    output logic [NUM_DEV-1:0] cs_n
);

    logic held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      held_q <= 1'b0;
        else if (!bus_en) held_q <= 1'b0;
        else if (done)    held_q <= hold;
    end

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_line
        assign cs_n[i] = !(bus_en && (dev == 2'(i)) && (busy || held_q));
    end

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R6

    AST_CS_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |-> (&cs_n)); // R8

endmodule

// File: rtl/bspi_master.sv
module bspi_master
    import bspi_pkg::*;
#(
    parameter int DIV_BASE = 4,
    parameter int NUM_DEV  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [15:0]        reg_wdata,
    output logic [15:0]        reg_rdata,
    output logic               spi_sclk,
    output logic               spi_mosi,
    input  logic               spi_miso,
    output logic [NUM_DEV-1:0] spi_cs_n,
    output logic               busy,
    output logic               irq
);

    bspi_ctrl_t        ctrl;
    logic              go, tick, done;
    logic [BYTE_W-1:0] tx_byte, rx_byte;

    bspi_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .busy    (busy),
        .rx_byte (rx_byte),
        .ctrl    (ctrl),
        .rdata   (reg_rdata),
        .go      (go),
        .tx_byte (tx_byte)
    );

    bspi_clkdiv #(.DIV_BASE(DIV_BASE), .RATE_W(2)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .rate  (ctrl.rate),
        .tick  (tick)
    );

    bspi_shifter #(.DATA_W(BYTE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .tx_byte (tx_byte),
        .tick    (tick),
        .miso    (spi_miso),
        .busy    (busy),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .done    (done),
        .rx_byte (rx_byte)
    );

    bspi_csel #(.NUM_DEV(NUM_DEV)) u_csel (
        .clk    (clk),
        .rst_n  (rst_n),
        .bus_en (ctrl.bus_en),
        .dev    (ctrl.dev),
        .hold   (ctrl.hold),
        .busy   (busy),
        .done   (done),
        .cs_n   (spi_cs_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= done && ctrl.irq_en;
    end

    AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($fell(busy) && ctrl.irq_en)); // R10

    AST_IRQ_GIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && ctrl.irq_en) |-> irq); // R10

endmodule

// File: tb/tb_bspi_master.sv
module tb_bspi_master;

    localparam int DIV_BASE = 4;
    localparam int NUM_DEV  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        spi_sclk, spi_mosi, busy, irq;
    logic        spi_miso = 1'b0;
    logic [NUM_DEV-1:0] spi_cs_n;

    always #5 clk = ~clk;

    bspi_master #(.DIV_BASE(DIV_BASE), .NUM_DEV(NUM_DEV)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n),
        .busy(busy), .irq(irq)
    );

    int checks = 0;
    int fails  = 0;

    // reference model state
    bit         model_on = 1'b0;
    int         m_t = -1;
    int         m_half = 2;
    logic [7:0] m_tx = 8'h00, m_slave = 8'h00, m_rx = 8'h00, slave_next = 8'h00;
    logic [1:0] m_rate = 2'd0, m_dev = 2'd0;
    bit         m_en = 0, m_irqen = 0, m_hold = 0, m_size = 0, m_held = 0;
    bit         exp_irq = 0, was_busy = 0;
    int         bit_i;

    function automatic int half_of(logic [1:0] r);
        return (DIV_BASE / 2) << r;
    endfunction

    function automatic logic [15:0] exp_ctrl();
        return {m_en, m_irqen, 2'b00, m_hold, m_size, m_dev, (m_t >= 0), 5'b00000, m_rate};
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (model_on) begin
            was_busy = (m_t >= 0);
            exp_irq  = 1'b0;
            if (m_t >= 0) begin
                m_t++;
                if (m_t == 17 * m_half) begin
                    m_t     = -1;
                    m_rx    = m_slave;
                    m_held  = m_hold;
                    exp_irq = m_irqen;
                end
            end
            if (reg_wr && !was_busy) begin
                if (reg_addr == 2'd0) begin
                    m_rate  = reg_wdata[1:0];
                    m_dev   = reg_wdata[9:8];
                    m_size  = reg_wdata[10];
                    m_hold  = reg_wdata[11];
                    m_irqen = reg_wdata[14];
                    m_en    = reg_wdata[15];
                    if (!m_en) m_held = 1'b0;
                end else if (reg_addr == 2'd2 && m_en) begin
                    m_t     = 0;
                    m_half  = half_of(m_rate);
                    m_tx    = reg_wdata[7:0];
                    m_slave = slave_next;
                end
            end
            chk(busy == (m_t >= 0), "R4", "busy", busy, (m_t >= 0));
            chk(spi_sclk == (m_t >= 0 && m_t < 16 * m_half && ((m_t / m_half) % 2 == 1)),
                "R3", "sclk", spi_sclk,
                (m_t >= 0 && m_t < 16 * m_half && ((m_t / m_half) % 2 == 1)));
            if (m_t >= 0 && m_t < 16 * m_half) begin
                bit_i = 7 - m_t / (2 * m_half);
                chk(spi_mosi == m_tx[bit_i], "R4", "mosi", spi_mosi, m_tx[bit_i]);
                spi_miso = m_slave[bit_i];
            end
            for (int i = 0; i < NUM_DEV; i++) begin
                chk(spi_cs_n[i] == !(m_en && m_dev == 2'(i) && (m_t >= 0 || m_held)),
                    "R6/R7/R8", "cs_n line", spi_cs_n[i],
                    !(m_en && m_dev == 2'(i) && (m_t >= 0 || m_held)));
            end
            chk(irq == exp_irq, "R10", "irq", irq, exp_irq);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string req);
        @(negedge clk); #1;
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, req, "read", reg_rdata, exp);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_t >= 0);
        @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] d, input logic [7:0] s);
        slave_next = s;
        wr(2'd2, {8'h00, d});
        wait_idle();
    endtask

    initial begin
        #1_500_000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1; model_on = 1'b1;
        // R1 reset state
        rd(2'd0, 16'h0000, "R1");
        rd(2'd2, 16'h0000, "R1");
        chk(spi_cs_n == 3'b111, "R1", "cs_n", spi_cs_n, 3'b111);
        chk(!spi_sclk && !busy && !irq, "R1", "idle outs", {spi_sclk, busy, irq}, 0);

        // R4 R5 R10: rate 0, device 0, interrupt on
        wr(2'd0, 16'hC000);
        xfer(8'hA5, 8'h3C);
        rd(2'd2, 16'h003C, "R5");

        // R3 rate 3, device 1; R9 writes while busy
        wr(2'd0, 16'h8103);
        slave_next = 8'h96;
        wr(2'd2, 16'h005A);
        repeat (20) @(negedge clk);
        wr(2'd2, 16'h00FF); // R9 data write ignored
        wr(2'd0, 16'h0000); // R9 control write ignored
        rd(2'd0, exp_ctrl(), "R9");
        chk(reg_rdata[7] == 1'b1, "R2", "busy bit", reg_rdata[7], 1);
        wait_idle();
        rd(2'd0, exp_ctrl(), "R9");
        rd(2'd2, 16'h0096, "R5");

        // R7 hold on device 2, rate 1
        wr(2'd0, 16'h8A01);
        xfer(8'h11, 8'h81);
        chk(spi_cs_n == 3'b011, "R7", "held cs", spi_cs_n, 3'b011);
        xfer(8'h22, 8'h7E);
        wr(2'd0, 16'h8201); // clear hold: line stays low
        chk(spi_cs_n == 3'b011, "R7", "held after clear", spi_cs_n, 3'b011);
        xfer(8'h33, 8'hC3);
        chk(spi_cs_n == 3'b111, "R7", "released", spi_cs_n, 3'b111);
        rd(2'd2, 16'h00C3, "R5");

        // R8 disable releases a held line and blocks starts
        wr(2'd0, 16'h8800);
        xfer(8'h44, 8'h5A);
        chk(spi_cs_n == 3'b110, "R7", "held dev0", spi_cs_n, 3'b110);
        wr(2'd0, 16'h0800);
        chk(spi_cs_n == 3'b111, "R8", "disabled cs", spi_cs_n, 3'b111);
        xfer(8'h55, 8'hE7);
        chk(!busy, "R8", "no start", busy, 0);
        rd(2'd2, 16'h005A, "R8");

        // R6 device code 3 selects nothing
        wr(2'd0, 16'h8302);
        slave_next = 8'h0F;
        wr(2'd2, 16'h00F0);
        chk(spi_cs_n == 3'b111, "R6", "code 3", spi_cs_n, 3'b111);
        wait_idle();
        rd(2'd2, 16'h000F, "R5");

        // R2 R11 all bits written, reserved read zero, size kept
        wr(2'd0, 16'hFFFF);
        rd(2'd0, 16'hCF03, "R2");
        rd(2'd0, exp_ctrl(), "R11");
        xfer(8'hC5, 8'h5C);
        rd(2'd2, 16'h005C, "R11");

        // R10 no pulse with interrupt disabled
        wr(2'd0, 16'h8000);
        xfer(8'h69, 8'hB4);
        rd(2'd2, 16'h00B4, "R10");

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule